// File: doc/BRIEF.md
# Carry-Select Adder with Early Operand Isolation

This block adds two unsigned operands and a carry-in, producing a sum and a carry-out. It is built from 4-bit groups. Each group has two speculative ripple adders, one assuming the incoming carry is 0 and one assuming it is 1. The true carry, chained upward from the lowest group, picks which result is used.

To cut wasted switching, the block looks at each group's incoming carry before the add starts. When the top bit pair of the group below is 1/1, that carry must be 1. When the pair is 0/0, it must be 0. In either case the speculative adder that can never be picked is isolated: its operand register keeps last cycle's value, so its logic sees no new transitions. The lowest group uses the primary carry-in in the same way. When the pair differs, both adders load.

Inputs are captured on the first clock edge and the result is registered on the second. The output therefore appears two edges after the inputs are presented. The operand width is a parameter and must be a multiple of four; 8, 16 and 32 bits are the intended sizes.

Top module: `gated_csa`

## Requirements
- R1: Two rising edges after a, b and carry-in are presented, {cout_o, sum_o} equals a + b + carry-in as an unsigned (DW+1)-bit value.
- R2: While the synchronous active-high reset is asserted, sum_o and cout_o are zero on the following edge.
- R3: For group g above the lowest, if operand bit 4g-1 is 1 in both a and b, the carry-0 speculative operands of group g keep their previous value on that edge.
- R4: For group g above the lowest, if operand bit 4g-1 is 0 in both a and b, the carry-1 speculative operands of group g keep their previous value on that edge.
- R5: For group g above the lowest, if operand bit 4g-1 differs between a and b, both speculative operand sets of group g load the current 4-bit slice.
- R6: For the lowest group, a carry-in of 1 holds its carry-0 operands, and a carry-in of 0 holds its carry-1 operands; the other set loads.
- R7: The sum stays exact whenever isolation is active, including full carry ripples across every group (for example all-ones plus carry-in 1).
- R8: The operand width DW is a parameter; it is split into DW/4 groups, and widths of 8 and 16 bits give exact results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | DW | First operand |
| b_i | input | DW | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | DW | Registered sum |
| cout_o | output | 1 | Registered carry-out |

## Verification
The main instance uses DW=8, which has two groups. At that width every combination of a, b and carry-in (131072 vectors) can be streamed one per cycle. This covers every gating pattern on bit 3 and on the carry-in, together with every ripple that crosses the group boundary.

A second instance uses DW=16, so carries chain through four groups and three group-boundary muxes. It is driven with directed all-ones and alternating patterns, then with random operands. The hold and load behaviour of the speculative operand registers is tracked cycle by cycle against the input bit pairs.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned GRP_W = 4;
endpackage

// File: rtl/csa_rca.sv
module csa_rca #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  input  logic          ci,
  output logic [GW-1:0] s,
  output logic          co
);
  logic [GW:0] c;
  always_comb begin
    c[0] = ci;
    for (int i = 0; i < GW; i++) begin
      s[i]   = a[i] ^ b[i] ^ c[i];
      c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end
    co = c[GW];
  end
endmodule

// File: rtl/csa_hold_reg.sv
module csa_hold_reg #(
  parameter int unsigned GW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [GW-1:0] a_d,
  input  logic [GW-1:0] b_d,
  output logic [GW-1:0] a_q,
  output logic [GW-1:0] b_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (!hold) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end
endmodule

// File: rtl/csa_spec_pair.sv
module csa_spec_pair #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] z_a,
  input  logic [GW-1:0] z_b,
  input  logic [GW-1:0] o_a,
  input  logic [GW-1:0] o_b,
  output logic [GW-1:0] z_s,
  output logic          z_c,
  output logic [GW-1:0] o_s,
  output logic          o_c
);
  csa_rca #(.GW(GW)) zero_i (.a(z_a), .b(z_b), .ci(1'b0), .s(z_s), .co(z_c));
  csa_rca #(.GW(GW)) one_i  (.a(o_a), .b(o_b), .ci(1'b1), .s(o_s), .co(o_c));
endmodule

// File: rtl/gated_csa.sv
module gated_csa #(
  parameter int unsigned DW = 32,
  parameter int unsigned GW = csa_pkg::GRP_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o
);
  localparam int unsigned NG = DW / GW;

  logic [NG-1:0]         hold0, hold1;
  logic [NG-1:0][GW-1:0] op0_a, op0_b, op1_a, op1_b;
  logic [NG-1:0][GW-1:0] s0, s1;
  logic [NG-1:0]         c0, c1;
  logic                  cin_q;
  logic [NG:0]           carry;
  logic [DW-1:0]         sum_d;

  for (genvar g = 0; g < NG; g++) begin : gen_grp
    if (g == 0) begin : gen_low
      // lowest group: the primary carry-in is already known
      assign hold0[g] = cin_i;
      assign hold1[g] = ~cin_i;
    end else begin : gen_up
      // top bit pair of the group below decides the carry into this group
      assign hold0[g] = a_i[GW*g-1] & b_i[GW*g-1];
      assign hold1[g] = ~(a_i[GW*g-1] | b_i[GW*g-1]);
    end

    csa_hold_reg #(.GW(GW)) r0_i (
      .clk(clk), .rst(rst), .hold(hold0[g]),
      .a_d(a_i[GW*g +: GW]), .b_d(b_i[GW*g +: GW]),
      .a_q(op0_a[g]), .b_q(op0_b[g])
    );
    csa_hold_reg #(.GW(GW)) r1_i (
      .clk(clk), .rst(rst), .hold(hold1[g]),
      .a_d(a_i[GW*g +: GW]), .b_d(b_i[GW*g +: GW]),
      .a_q(op1_a[g]), .b_q(op1_b[g])
    );
    csa_spec_pair #(.GW(GW)) sp_i (
      .z_a(op0_a[g]), .z_b(op0_b[g]), .o_a(op1_a[g]), .o_b(op1_b[g]),
      .z_s(s0[g]), .z_c(c0[g]), .o_s(s1[g]), .o_c(c1[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) cin_q <= 1'b0;
    else     cin_q <= cin_i;
  end

  // selection chain: an isolated block is never the one picked
  always_comb begin
    carry[0] = cin_q;
    for (int g = 0; g < NG; g++) begin
      sum_d[GW*g +: GW] = carry[g] ? s1[g] : s0[g];
      carry[g+1]        = carry[g] ? c1[g] : c0[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_d;
      cout_o <= carry[NG];
    end
  end
endmodule

// File: rtl/gated_csa_chk.sv
module gated_csa_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned GW = 4,
  parameter int unsigned NG = DW / GW
) (
  input logic                  clk,
  input logic                  rst,
  input logic [DW-1:0]         a_i,
  input logic [DW-1:0]         b_i,
  input logic                  cin_i,
  input logic [DW-1:0]         sum_o,
  input logic                  cout_o,
  input logic [NG-1:0][GW-1:0] op0_a,
  input logic [NG-1:0][GW-1:0] op0_b,
  input logic [NG-1:0][GW-1:0] op1_a,
  input logic [NG-1:0][GW-1:0] op1_b
);
  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst)            live <= 2'd0;
    else if (live != 3) live <= live + 2'd1;
  end

  // R1: result equals the arithmetic sum of inputs two edges earlier
  a_r1_sum: assert property (@(posedge clk) disable iff (rst)
    (live >= 2) |-> ({cout_o, sum_o} ==
      $past({1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin_i}, 2)));

  // R6: lowest group follows the carry-in
  a_r6_low_hold0: assert property (@(posedge clk) disable iff (rst)
    cin_i |=> ($stable(op0_a[0]) && $stable(op0_b[0])));
  a_r6_low_hold1: assert property (@(posedge clk) disable iff (rst)
    !cin_i |=> ($stable(op1_a[0]) && $stable(op1_b[0])));
  a_r6_low_load: assert property (@(posedge clk) disable iff (rst)
    !cin_i |=> (op0_a[0] == $past(a_i[GW-1:0]) && op0_b[0] == $past(b_i[GW-1:0])));

  for (genvar g = 1; g < NG; g++) begin : gen_chk
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
      (a_i[GW*g-1] && b_i[GW*g-1]) |=> ($stable(op0_a[g]) && $stable(op0_b[g])));
    a_r4_hold_one: assert property (@(posedge clk) disable iff (rst)
      (!a_i[GW*g-1] && !b_i[GW*g-1]) |=> ($stable(op1_a[g]) && $stable(op1_b[g])));
    a_r5_load_both: assert property (@(posedge clk) disable iff (rst)
      (a_i[GW*g-1] != b_i[GW*g-1]) |=>
        (op0_a[g] == $past(a_i[GW*g +: GW]) && op1_b[g] == $past(b_i[GW*g +: GW])));
  end
endmodule

bind gated_csa gated_csa_chk #(.DW(DW), .GW(GW)) chk_i (
  .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
  .sum_o(sum_o), .cout_o(cout_o),
  .op0_a(op0_a), .op0_b(op0_b), .op1_a(op1_a), .op1_b(op1_b)
);

// File: tb/gated_csa_tb_top.sv
module gated_csa_tb_top;
  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic [7:0]  a8, b8, s8;
  logic        c8, co8;
  logic [15:0] a16, b16, s16;
  logic        c16, co16;

  gated_csa #(.DW(8)) dut_i (
    .clk(clk), .rst(rst), .a_i(a8), .b_i(b8), .cin_i(c8), .sum_o(s8), .cout_o(co8)
  );
  gated_csa #(.DW(16)) dut_w16_i (
    .clk(clk), .rst(rst), .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input logic [16:0] got, input logic [16:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  logic [8:0]  e8  [2];
  logic [16:0] e16 [2];
  string       t8  [2];
  bit          v8  [2];
  bit          v16 [2];

  localparam int N8 = 131072;

  initial begin
    rst = 1'b1;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = 16'hFFFF; b16 = 16'hFFFF; c16 = 1'b1;
    for (int k = 0; k < 2; k++) begin v8[k] = 0; v16[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({8'd0, co8, s8}, 17'd0, "R2 reset w8");
    check({co16, s16}, 17'd0, "R2 reset w16");
    rst = 1'b0;
    for (int i = 0; i < N8 + 2; i++) begin
      int sl;
      logic [16:0] ra, rb;
      sl = i % 2;
      if (i > 0) @(negedge clk);
      if (v8[sl])  check({8'd0, co8, s8}, {8'd0, e8[sl]}, t8[sl]);
      if (v16[sl]) check({co16, s16}, e16[sl], "R1/R7/R8 w16");
      if (i < N8) begin
        a8 = i[16:9]; b8 = i[8:1]; c8 = i[0];
        e8[sl] = {1'b0, a8} + {1'b0, b8} + {8'd0, c8};
        t8[sl] = $sformatf("R1/%s/R6/R7 a=%h b=%h c=%0d",
                  (a8[3] & b8[3]) ? "R3" : (!a8[3] & !b8[3]) ? "R4" : "R5", a8, b8, c8);
        v8[sl] = 1;
        case (i)
          0: begin a16 = 16'hFFFF; b16 = 16'h0000; c16 = 1'b1; end
          1: begin a16 = 16'h8888; b16 = 16'h8888; c16 = 1'b1; end
          2: begin a16 = 16'h7777; b16 = 16'h0001; c16 = 1'b0; end
          3: begin a16 = 16'hAAAA; b16 = 16'h5555; c16 = 1'b1; end
          4: begin a16 = 16'hFFFF; b16 = 16'hFFFF; c16 = 1'b1; end
          default: begin
            ra = 17'($urandom); rb = 17'($urandom);
            a16 = ra[15:0]; b16 = rb[15:0]; c16 = ra[16];
          end
        endcase
        e16[sl] = {1'b0, a16} + {1'b0, b16} + {16'd0, c16};
        v16[sl] = 1;
      end else begin
        v8[sl] = 0; v16[sl] = 0;
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule